// File: doc/BRIEF.md
# Sixteen-Bit Skip-Group Carry Adder

This block adds two unsigned 16-bit operands and a carry-in. The operands are split into four slices of four bits each. For every bit, a setup stage forms a propagate flag and a generate flag from the two operand bits alone. Inside each slice a carry then ripples bit by bit.

Each slice also has a skip multiplexer. When every bit of the slice propagates, the multiplexer takes the slice's incoming carry straight to its outgoing carry, so the carry does not wait for the slice's own chain. Each sum bit is the bit's propagate flag XOR the carry that arrives at that bit.

The combinational adder sits inside a thin registered wrapper, which gives a fixed one-cycle latency from an operand strobe to a result strobe. The slice width and the total width are parameters; the defaults are four slices of four bits.

Top module: `cba_adder`

## Requirements
- R1: One cycle after a clock edge that samples `in_valid` high, `{cout, sum}` equals `a + b + cin` for the sampled operands, computed to 17 bits.
- R2: `out_valid` equals `in_valid` as sampled at the previous edge. An edge that samples `rst` high sets `out_valid`, `sum` and `cout` to 0.
- R3: When all four bits of a slice propagate (`a ^ b` is all ones over the slice), the slice's carry-out equals its carry-in. For example, `a = 16'hFFFF`, `b = 0` gives `sum = 16'hFFFF`, `cout = 0` for `cin = 0`, and `sum = 0`, `cout = 1` for `cin = 1`.
- R4: A carry made in one slice enters the next slice at its lowest bit. For example, `16'h000F + 16'h0001` gives `16'h0010`.
- R5: A carry stops at the first bit where both operand bits are 0. A bit where both operand bits are 1 produces a carry whatever carry reaches it.
- R6: While `in_valid` is low, `sum` and `cout` keep their previous values, whatever happens on `a`, `b` and `cin`.
- R7: `cout` is the carry-out of the top slice. For example, `16'h8000 + 16'h8000` gives `sum = 0`, `cout = 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe; captures the result at the next edge |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| sum | output | 16 | Registered sum |
| cout | output | 1 | Registered carry out of the top slice |

## Verification
On every cycle, the assertions compare the registered result with an arithmetic sum of the operands from one cycle earlier. They also check that each slice's skip multiplexer never disagrees with its own ripple chain, and that a slice with all bits propagating hands its incoming carry on unchanged. The valid-strobe timing and the holding of results during idle cycles are checked every cycle as well. The particular carry paths, such as a carry running through all four skip multiplexers or a carry stopped by a bit where both operands are 0, only happen when the bench drives the directed operand patterns that cause them.

// File: rtl/cba_pkg.sv
package cba_pkg;

    localparam int unsigned CBA_WIDTH = 16;
    localparam int unsigned CBA_SLICE = 4;

    typedef struct packed {
        logic prop;
        logic gen;
    } pg_bit_t;

    function automatic pg_bit_t pg_form(input logic x, input logic y);
        pg_bit_t r;
        r.prop = x ^ y;
        r.gen  = x & y;
        return r;
    endfunction

    function automatic logic carry_step(input pg_bit_t pg, input logic c);
        return pg.gen | (pg.prop & c);
    endfunction

endpackage

// File: rtl/cba_setup.sv
module cba_setup
    import cba_pkg::*;
#(
    parameter int unsigned WIDTH = CBA_WIDTH
) (
    input  logic [WIDTH-1:0]    a,
    input  logic [WIDTH-1:0]    b,
    output pg_bit_t [WIDTH-1:0] pg
);
    // Per-bit flags depend only on the operand bits.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pg[i] = pg_form(a[i], b[i]);
    end
endmodule

// File: rtl/cba_slice.sv
module cba_slice
    import cba_pkg::*;
#(
    parameter int unsigned SLICE = CBA_SLICE
) (
    input  pg_bit_t [SLICE-1:0] pg,
    input  logic                c_in,
    output logic [SLICE-1:0]    s,
    output logic                skip,
    output logic                ripple,
    output logic                c_out
);
    logic [SLICE-1:0] p_vec;
    logic [SLICE-1:0] c_bit;

    // Local ripple chain over the slice.
    always_comb begin
        logic c;
        c = c_in;
        for (int i = 0; i < SLICE; i++) begin
            p_vec[i] = pg[i].prop;
            c_bit[i] = c;
            c        = carry_step(pg[i], c);
        end
        ripple = c;
    end

    assign s     = p_vec ^ c_bit;
    assign skip  = &p_vec;
    // Skip multiplexer: when all bits propagate, forward the incoming carry.
    assign c_out = skip ? c_in : ripple;
endmodule

// File: rtl/cba_core.sv
module cba_core
    import cba_pkg::*;
#(
    parameter int unsigned WIDTH = CBA_WIDTH,
    parameter int unsigned SLICE = CBA_SLICE,
    localparam int unsigned NGRP = WIDTH / SLICE
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic [NGRP-1:0]  grp_skip,
    output logic [NGRP-1:0]  grp_cin,
    output logic [NGRP-1:0]  grp_ripple,
    output logic [NGRP-1:0]  grp_cout
);
    pg_bit_t [WIDTH-1:0] pg;

    cba_setup #(.WIDTH(WIDTH)) u_setup (
        .a  (a),
        .b  (b),
        .pg (pg)
    );

    for (genvar k = 0; k < NGRP; k++) begin : g_slice
        if (k == 0) begin : g_first
            assign grp_cin[k] = cin;
        end else begin : g_next
            assign grp_cin[k] = grp_cout[k-1];
        end

        cba_slice #(.SLICE(SLICE)) u_slice (
            .pg     (pg[k*SLICE +: SLICE]),
            .c_in   (grp_cin[k]),
            .s      (sum[k*SLICE +: SLICE]),
            .skip   (grp_skip[k]),
            .ripple (grp_ripple[k]),
            .c_out  (grp_cout[k])
        );
    end

    assign cout = grp_cout[NGRP-1];
endmodule

// File: rtl/cba_adder.sv
module cba_adder
    import cba_pkg::*;
#(
    parameter int unsigned WIDTH = CBA_WIDTH,
    parameter int unsigned SLICE = CBA_SLICE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic             out_valid,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int unsigned NGRP = WIDTH / SLICE;

    logic [WIDTH-1:0] core_sum;
    logic             core_cout;
    logic [NGRP-1:0]  grp_skip;
    logic [NGRP-1:0]  grp_cin;
    logic [NGRP-1:0]  grp_ripple;
    logic [NGRP-1:0]  grp_cout;

    cba_core #(.WIDTH(WIDTH), .SLICE(SLICE)) u_core (
        .a          (a),
        .b          (b),
        .cin        (cin),
        .sum        (core_sum),
        .cout       (core_cout),
        .grp_skip   (grp_skip),
        .grp_cin    (grp_cin),
        .grp_ripple (grp_ripple),
        .grp_cout   (grp_cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            sum       <= '0;
            cout      <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum  <= core_sum;
                cout <= core_cout;
            end
        end
    end
endmodule

// File: rtl/cba_adder_chk.sv
module cba_adder_chk #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned NGRP  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic             out_valid,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [NGRP-1:0]  grp_skip,
    input logic [NGRP-1:0]  grp_cin,
    input logic [NGRP-1:0]  grp_ripple,
    input logic [NGRP-1:0]  grp_cout
);
    logic [WIDTH:0] arith;
    assign arith = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    // R1, R7: registered result matches arithmetic sum of previous operands
    p_sum_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ({cout, sum} == $past(arith)));

    // R2: strobe follows one cycle later
    p_valid_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3: a slice whose bits all propagate passes its carry unchanged
    p_skip_r3: assert property (@(posedge clk) disable iff (rst)
        ((grp_ripple ^ grp_cin) & grp_skip) == '0);
    // R3, R5: skip multiplexer never disagrees with the ripple chain
    p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
        (grp_cout ^ grp_ripple) == '0);

    // R6: results hold while no operand is strobed
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(sum) && $stable(cout)));
endmodule

bind cba_adder cba_adder_chk #(.WIDTH(WIDTH), .NGRP(NGRP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .a          (a),
    .b          (b),
    .cin        (cin),
    .out_valid  (out_valid),
    .sum        (sum),
    .cout       (cout),
    .grp_skip   (grp_skip),
    .grp_cin    (grp_cin),
    .grp_ripple (grp_ripple),
    .grp_cout   (grp_cout)
);

// File: tb/cba_adder_bench.sv
module cba_adder_bench;
    localparam int  W        = 16;
    localparam time CLK_HALF = 5ns;
    localparam int  WATCHDOG = 20000;

    typedef struct {
        logic [W:0] exp;
        string      tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic         out_valid;
    logic [W-1:0] sum;
    logic         cout;

    item_t sb[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    done     = 1'b0;
    logic [W:0] last_out = '0;

    cba_adder u_cba_adder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b), .cin(cin),
        .out_valid(out_valid), .sum(sum), .cout(cout)
    );

    always #(CLK_HALF) clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [W:0] act, input logic [W:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: present operands at the falling edge and queue the expected result.
    task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic c, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; a = x; b = y; cin = c;
        it.exp = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        @(negedge clk);
        in_valid = 1'b0; a = x; b = y; cin = c;
    endtask

    // Monitor: sample just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst) begin
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R2 unexpected out_valid", {cout, sum}, '0);
                    end else begin
                        item_t it;
                        it = sb.pop_front();
                        check({cout, sum} == it.exp, it.tag, {cout, sum}, it.exp);
                    end
                end else begin
                    check({cout, sum} == last_out, "R6 hold while idle", {cout, sum}, last_out);
                end
                last_out = {cout, sum};
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        check({out_valid, cout, sum} == '0, "R2 reset state", {cout, sum}, '0);
        rst = 1'b0;

        // R3, R7: all-propagate patterns
        drive(16'hFFFF, 16'h0000, 1'b0, "R3 all propagate cin0");
        drive(16'hFFFF, 16'h0000, 1'b1, "R3 all propagate cin1 R7");
        drive(16'hF0F0, 16'h0F0F, 1'b1, "R3 mixed propagate cin1");
        drive(16'hF0F0, 16'h0F0F, 1'b0, "R3 mixed propagate cin0");
        // R4: carry crossing a slice boundary
        drive(16'h000F, 16'h0001, 1'b0, "R4 slice0 to slice1");
        drive(16'h0FFF, 16'h0000, 1'b1, "R4 carry through three slices");
        drive(16'h0F00, 16'h0100, 1'b0, "R4 slice2 to slice3");
        // R5: kill and generate bits
        drive(16'h00F7, 16'h0008, 1'b1, "R5 carry stopped by zero bit");
        drive(16'h0080, 16'h0080, 1'b0, "R5 generate inside slice");
        drive(16'h0F08, 16'h00F8, 1'b0, "R5 generate then skip");
        // R7: top carry
        drive(16'h8000, 16'h8000, 1'b0, "R7 top carry");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R7 all generate");
        // R6: idle cycles with changing operands
        idle(16'h1234, 16'h4321, 1'b1);
        idle(16'hFFFF, 16'hFFFF, 1'b1);
        idle(16'h0000, 16'h0001, 1'b0);
        // R1: random vectors, occasionally idle
        for (int i = 0; i < 300; i++) begin
            drive(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
            if (($urandom % 7) == 0) idle(16'($urandom), 16'($urandom), 1'($urandom));
        end
        idle('0, '0, 1'b0);
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R1 all results returned", (W+1)'(sb.size()), '0);
        // R2: reset clears result
        rst = 1'b1;
        @(negedge clk);
        check({out_valid, cout, sum} == '0, "R2 reset clears", {cout, sum}, '0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule